// File: doc/BRIEF.md
# Configurable-Frame Asynchronous Serial Transceiver

This block moves characters between a parallel interface and a pair of asynchronous serial lines. The character format is chosen at run time from three small fields: character length (5 to 8 data bits), parity (none, even or odd) and stop length (half, one or two bit times). Bit timing comes from an external enable, `baud_tick`, that pulses sixteen times per bit period. The block does not divide any clock itself.

Transmit data enters through a valid/ready port. A word is accepted on a clock edge where both `tx_valid` and `tx_ready` are high. `tx_ready` stays low while the single holding slot in front of the shift register is occupied, and that is the only back-pressure on the port. Received characters leave through a second valid/ready port. `rx_valid` stays high and `rx_word` stays stable until the consumer raises `rx_ready`. A character that arrives while both receive slots are full is dropped, and this is signalled by a one-cycle `rx_overflow` pulse. Each direction has its own enable and disable strobes. When the transmitter is disabled, the line stays high and any pending character waits in the holding slot.

Top module: `uart_frame_xcvr`

## Requirements
- R1: The character length is `cfg_len_code` + 3 bits, valid for codes 2 to 5. Data goes out least significant bit first, after one low start bit. Data bits above the length are neither sent nor returned.
- R2: `cfg_parity` selects the parity: 00 or 01 gives no parity bit, 10 gives even parity and 11 gives odd parity. The parity bit follows the last data bit and covers only the data bits.
- R3: `cfg_stop` selects the stop length: 00 gives 8 ticks, 01 or 10 gives 16 ticks and 11 gives 32 ticks of high line.
- R4: The receiver checks only the first stop bit. With two stop bits configured, a character followed by a single high stop bit is still received without error.
- R5: A received word has the data in bits [8:0], zero-extended. Bit 14 is set on a parity mismatch and bit 15 is set when the first stop bit is sampled low. Bits [13:9] are zero.
- R6: A line held low for longer than a whole character is reported as one word with bit 15 set and the data field zero.
- R7: Up to two received words are held. A word completed while both slots are full and no word is being read is dropped, and `rx_overflow` pulses for one cycle. The stored words are unchanged.
- R8: `cmd_tx_en` and `cmd_tx_dis` set and clear the transmitter enable, and disable wins when both strobes arrive together. `stat_tx_on` shows the result one cycle after the strobe.
- R9: While the transmitter is disabled, `txd` stays high and an accepted character is kept. It is sent once the transmitter is enabled.
- R10: While the receiver is disabled (`cmd_rx_dis`, and also the state after reset), line activity produces no word.
- R11: `stat_tx_room` is high while the holding slot is empty. `stat_tx_idle` is high only when both the holding slot and the shift register are empty.
- R12: A start bit is accepted only if the line is still low 8 ticks after the falling edge. Shorter low pulses produce no word.
- R13: Stream rules: a transmit word is taken only when `tx_valid` and `tx_ready` are both high. `rx_word` holds steady while `rx_valid` is high and `rx_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Enable pulsing 16 times per bit |
| cfg_len_code | input | 4 | Character length minus 3 |
| cfg_parity | input | 2 | Parity mode |
| cfg_stop | input | 2 | Stop length |
| cmd_tx_en | input | 1 | Transmitter enable strobe |
| cmd_tx_dis | input | 1 | Transmitter disable strobe |
| cmd_rx_en | input | 1 | Receiver enable strobe |
| cmd_rx_dis | input | 1 | Receiver disable strobe |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Holding slot can take a word |
| tx_data | input | 8 | Transmit character |
| rxd | input | 1 | Serial receive line |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer takes the received word |
| rx_word | output | 16 | Received word with error flags |
| txd | output | 1 | Serial transmit line |
| stat_tx_on | output | 1 | Transmitter enabled |
| stat_tx_room | output | 1 | Transmit buffer has room |
| stat_tx_idle | output | 1 | Transmission complete |
| stat_rx_avail | output | 1 | Receive data valid |
| rx_overflow | output | 1 | One-cycle pulse when a received word is dropped |

## Verification
The properties assume that each command strobe lasts one cycle and that `tx_data` stays stable while `tx_valid` waits. They also assume the format fields change only while no character is in flight on either line, and that `baud_tick` is a single-cycle pulse no more often than every other clock. The stimulus issues strobes through tasks that hold them for one clock. It changes the format only after the transmitter reports idle and the receive queue has drained, and it generates the tick from a fixed divide-by-4 counter. The receive line is driven by a behavioural serializer whose bit period is 64 clocks, or looped back from `txd`.

// File: rtl/uart_xcvr_pkg.sv
package uart_xcvr_pkg;
  localparam int LEN_W    = 4;
  localparam int WORD_W   = 16;
  localparam int DFIELD_W = 9;
  localparam int PERR_POS = 14;
  localparam int FERR_POS = 15;
  localparam int MIN_LEN  = 5;

  typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} tx_state_e;
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_WAITHI} rx_state_e;

  // last tick index of the stop phase: half, one (also code 10), two bits
  function automatic logic [4:0] tx_stop_limit(input logic [1:0] sel);
    case (sel)
      2'b00:   return 5'd7;
      2'b11:   return 5'd31;
      default: return 5'd15;
    endcase
  endfunction
endpackage

// File: rtl/uart_xcvr_tx.sv
module uart_xcvr_tx
  import uart_xcvr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic [LEN_W-1:0] len,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic [1:0]       stop_sel,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  output logic             txd,
  output logic             idle
);
  tx_state_e        st_q;
  logic             hold_full;
  logic [DW-1:0]    hold_q, shift_q;
  logic [4:0]       tcnt_q, lim;
  logic [LEN_W-1:0] bidx_q;
  logic             par_q, line_q, load;

  function automatic logic calc_par(input logic [DW-1:0] d, input logic [LEN_W-1:0] n,
                                    input logic odd);
    logic p;
    p = odd;
    for (int i = 0; i < DW; i++) if (i < int'(n)) p ^= d[i];
    return p;
  endfunction

  assign in_ready = !hold_full;
  assign load     = en && (st_q == TX_IDLE) && hold_full;
  assign lim      = (st_q == TX_STOP) ? tx_stop_limit(stop_sel) : 5'd15;
  assign txd      = line_q;
  assign idle     = !hold_full && (st_q == TX_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= TX_IDLE; hold_full <= 1'b0; hold_q <= '0; shift_q <= '0;
      tcnt_q <= '0; bidx_q <= '0; par_q <= 1'b0; line_q <= 1'b1;
    end else begin
      if (in_valid && in_ready) begin
        hold_full <= 1'b1;
        hold_q    <= in_data;
      end else if (load) begin
        hold_full <= 1'b0;
      end
      case (st_q)
        TX_IDLE: begin
          line_q <= 1'b1;
          if (load) begin
            shift_q <= hold_q;
            par_q   <= calc_par(hold_q, len, par_odd);
            st_q    <= TX_START;
            tcnt_q  <= '0;
            line_q  <= 1'b0;
          end
        end
        default: if (tick) begin
          if (tcnt_q != lim) begin
            tcnt_q <= tcnt_q + 5'd1;
          end else begin
            tcnt_q <= '0;
            case (st_q)
              TX_START: begin
                st_q   <= TX_DATA;
                bidx_q <= '0;
                line_q <= shift_q[0];
              end
              TX_DATA: begin
                if (bidx_q == len - 4'd1) begin
                  if (par_en) begin st_q <= TX_PAR;  line_q <= par_q; end
                  else        begin st_q <= TX_STOP; line_q <= 1'b1;  end
                end else begin
                  bidx_q  <= bidx_q + 4'd1;
                  shift_q <= shift_q >> 1;
                  line_q  <= shift_q[1];
                end
              end
              TX_PAR:  begin st_q <= TX_STOP; line_q <= 1'b1; end
              default: begin st_q <= TX_IDLE; line_q <= 1'b1; end
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/uart_xcvr_rx.sv
module uart_xcvr_rx
  import uart_xcvr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  logic              line,
  input  logic [LEN_W-1:0]  len,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              stop_half,
  output logic              word_valid,
  output logic [WORD_W-1:0] word
);
  localparam int IW = $clog2(DW);

  rx_state_e            st_q;
  logic [3:0]           tcnt_q;
  logic [LEN_W-1:0]     bidx_q;
  logic [DW-1:0]        data_q;
  logic                 pbit_q;
  logic [3:0]           stop_lim;
  logic [DFIELD_W-1:0]  dfield;

  assign stop_lim = stop_half ? 4'd11 : 4'd15;

  always_comb begin
    dfield = '0;
    dfield[DW-1:0] = data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= RX_IDLE; tcnt_q <= '0; bidx_q <= '0; data_q <= '0; pbit_q <= 1'b0;
      word_valid <= 1'b0; word <= '0;
    end else begin
      word_valid <= 1'b0;
      if (!en) begin
        st_q <= RX_IDLE;
      end else begin
        case (st_q)
          RX_IDLE: if (!line) begin st_q <= RX_START; tcnt_q <= '0; end
          RX_START: if (tick) begin
            if (tcnt_q != 4'd7) tcnt_q <= tcnt_q + 4'd1;
            else if (!line) begin
              st_q <= RX_DATA; tcnt_q <= '0; bidx_q <= '0; data_q <= '0;
            end else st_q <= RX_IDLE;
          end
          RX_DATA: if (tick) begin
            if (tcnt_q != 4'd15) tcnt_q <= tcnt_q + 4'd1;
            else begin
              tcnt_q <= '0;
              data_q[bidx_q[IW-1:0]] <= line;
              if (bidx_q == len - 4'd1) st_q <= par_en ? RX_PAR : RX_STOP;
              else bidx_q <= bidx_q + 4'd1;
            end
          end
          RX_PAR: if (tick) begin
            if (tcnt_q != 4'd15) tcnt_q <= tcnt_q + 4'd1;
            else begin tcnt_q <= '0; pbit_q <= line; st_q <= RX_STOP; end
          end
          RX_STOP: if (tick) begin
            if (tcnt_q != stop_lim) tcnt_q <= tcnt_q + 4'd1;
            else begin
              tcnt_q     <= '0;
              word_valid <= 1'b1;
              word       <= '0;
              word[DFIELD_W-1:0] <= dfield;
              word[FERR_POS]     <= !line;
              word[PERR_POS]     <= par_en && ((^data_q) ^ pbit_q ^ par_odd);
              st_q       <= RX_WAITHI;
            end
          end
          default: if (line) st_q <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_xcvr_rxbuf.sv
module uart_xcvr_rxbuf #(
  parameter int W     = 16,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic         valid,
  output logic [W-1:0] dout,
  output logic         overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [AW:0]   cnt_q;
  logic          full, do_pop, do_push;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == (AW+1)'(DEPTH));
  assign valid   = (cnt_q != '0);
  assign dout    = mem[rd_q];
  assign do_pop  = pop && valid;
  assign do_push = push && (!full || do_pop);

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0; wr_q <= '0; cnt_q <= '0; overflow <= 1'b0;
    end else begin
      overflow <= push && !do_push;
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/uart_frame_xcvr.sv
module uart_frame_xcvr
  import uart_xcvr_pkg::*;
#(
  parameter int DW          = 8,
  parameter int RX_DEPTH    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic [LEN_W-1:0]  cfg_len_code,
  input  logic [1:0]        cfg_parity,
  input  logic [1:0]        cfg_stop,
  input  logic              cmd_tx_en,
  input  logic              cmd_tx_dis,
  input  logic              cmd_rx_en,
  input  logic              cmd_rx_dis,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DW-1:0]     tx_data,
  input  logic              rxd,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [WORD_W-1:0] rx_word,
  output logic              txd,
  output logic              stat_tx_on,
  output logic              stat_tx_room,
  output logic              stat_tx_idle,
  output logic              stat_rx_avail,
  output logic              rx_overflow
);
  logic [LEN_W-1:0]       len_raw, len;
  logic                   par_en, par_odd;
  logic                   tx_on_q, rx_on_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_push;
  logic [WORD_W-1:0]      rx_new;

  assign len_raw = cfg_len_code + 4'd3;
  assign len     = (len_raw < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) :
                   (len_raw > LEN_W'(DW))      ? LEN_W'(DW) : len_raw;
  assign par_en  = cfg_parity[1];
  assign par_odd = cfg_parity[1] & cfg_parity[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_on_q <= 1'b0;
      rx_on_q <= 1'b0;
      sync_q  <= '1;
    end else begin
      if (cmd_tx_dis)     tx_on_q <= 1'b0;
      else if (cmd_tx_en) tx_on_q <= 1'b1;
      if (cmd_rx_dis)     rx_on_q <= 1'b0;
      else if (cmd_rx_en) rx_on_q <= 1'b1;
      sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
    end
  end

  uart_xcvr_tx #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .en(tx_on_q), .len(len),
    .par_en(par_en), .par_odd(par_odd), .stop_sel(cfg_stop),
    .in_valid(tx_valid), .in_ready(tx_ready), .in_data(tx_data),
    .txd(txd), .idle(stat_tx_idle)
  );

  uart_xcvr_rx #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .en(rx_on_q),
    .line(sync_q[SYNC_STAGES-1]), .len(len), .par_en(par_en), .par_odd(par_odd),
    .stop_half(cfg_stop == 2'b00), .word_valid(rx_push), .word(rx_new)
  );

  uart_xcvr_rxbuf #(.W(WORD_W), .DEPTH(RX_DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_new), .pop(rx_ready),
    .valid(rx_valid), .dout(rx_word), .overflow(rx_overflow)
  );

  assign stat_tx_on    = tx_on_q;
  assign stat_tx_room  = tx_ready;
  assign stat_rx_avail = rx_valid;
endmodule

// File: rtl/uart_frame_xcvr_chk.sv
module uart_frame_xcvr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_tx_en,
  input logic        cmd_tx_dis,
  input logic        stat_tx_on,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic        stat_tx_idle,
  input logic        txd,
  input logic        rx_valid,
  input logic        rx_ready,
  input logic [15:0] rx_word,
  input logic        rx_overflow
);
  a_r8_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_tx_en && !cmd_tx_dis |=> stat_tx_on);
  a_r8_disable_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_tx_dis |=> !stat_tx_on);
  a_r11_idle_has_room: assert property (@(posedge clk) disable iff (!rst_n)
    stat_tx_idle |-> tx_ready);
  a_r11_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    stat_tx_idle |-> txd);
  a_r13_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !stat_tx_idle);
  a_r13_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_word));
  a_r7_overflow_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overflow |-> rx_valid);
  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> rx_word[13:9] == 5'd0);
endmodule

bind uart_frame_xcvr uart_frame_xcvr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_tx_en(cmd_tx_en), .cmd_tx_dis(cmd_tx_dis),
  .stat_tx_on(stat_tx_on), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .stat_tx_idle(stat_tx_idle), .txd(txd), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_word(rx_word), .rx_overflow(rx_overflow)
);

// File: tb/sim_uart_frame_xcvr.sv
module sim_uart_frame_xcvr;
  localparam int CLK_NS   = 10;
  localparam int TICK_DIV = 4;
  localparam int BITC     = 16 * TICK_DIV;

  logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0;
  logic [3:0] cfg_len_code = 4'd5;
  logic [1:0] cfg_parity = 2'b00, cfg_stop = 2'b01;
  logic cmd_tx_en = 0, cmd_tx_dis = 0, cmd_rx_en = 0, cmd_rx_dis = 0;
  logic tx_valid = 0, tx_ready, rx_valid, rx_ready = 1'b1;
  logic [7:0] tx_data = 8'h00;
  logic [15:0] rx_word;
  logic txd, stat_tx_on, stat_tx_room, stat_tx_idle, stat_rx_avail, rx_overflow;
  logic loop = 1'b0, drv = 1'b1, rxd;
  int   tdiv = 0;

  int n_run = 0, n_fail = 0, ovf_cnt = 0;
  int b_len = 8, b_par = 0, b_stop = 1;
  bit m_tx_on = 0;
  int exp_q[$];
  int tx_exp[$];

  assign rxd = loop ? txd : drv;

  uart_frame_xcvr u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .cfg_len_code(cfg_len_code),
    .cfg_parity(cfg_parity), .cfg_stop(cfg_stop), .cmd_tx_en(cmd_tx_en),
    .cmd_tx_dis(cmd_tx_dis), .cmd_rx_en(cmd_rx_en), .cmd_rx_dis(cmd_rx_dis),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .rxd(rxd),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_word(rx_word), .txd(txd),
    .stat_tx_on(stat_tx_on), .stat_tx_room(stat_tx_room), .stat_tx_idle(stat_tx_idle),
    .stat_rx_avail(stat_rx_avail), .rx_overflow(rx_overflow)
  );

  always #(CLK_NS/2) clk = ~clk;

  always @(posedge clk) begin
    tdiv      <= (tdiv == TICK_DIV-1) ? 0 : tdiv + 1;
    baud_tick <= (tdiv == TICK_DIV-1);
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int mask_of(input int len);
    return (1 << len) - 1;
  endfunction

  function automatic bit par_of(input int d, input int len, input int mode);
    bit p;
    p = (mode == 2);
    for (int i = 0; i < len; i++) p ^= d[i];
    return p;
  endfunction

  // per-clock reference comparison
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk(stat_tx_on == m_tx_on, "R8", "tx enable status", stat_tx_on, m_tx_on);
      if (rx_overflow) ovf_cnt++;
      if (rx_valid && rx_ready) begin
        if (exp_q.size() == 0) chk(0, "R10", "unexpected rx word", rx_word, -1);
        else begin
          chk(rx_word == 16'(exp_q[0]), "R5", "rx word", rx_word, exp_q[0]);
          void'(exp_q.pop_front());
        end
      end
    end
  end

  // behavioural decoder of the transmit line
  initial begin
    forever begin
      int v;
      bit p;
      @(negedge txd);
      repeat (BITC/2) @(negedge clk);
      chk(txd == 1'b0, "R1", "start bit", txd, 0);
      v = 0;
      for (int i = 0; i < b_len; i++) begin
        repeat (BITC) @(negedge clk);
        v[i] = txd;
      end
      if (b_par != 0) begin
        repeat (BITC) @(negedge clk);
        p = txd;
        chk(p == par_of(v, b_len, b_par), "R2", "tx parity bit", p, par_of(v, b_len, b_par));
      end
      repeat ((b_stop == 0) ? (BITC*3/4) : BITC) @(negedge clk);
      chk(txd == 1'b1, "R3", "first stop level", txd, 1);
      if (b_stop == 2) begin
        repeat (BITC) @(negedge clk);
        chk(txd == 1'b1, "R3", "second stop level", txd, 1);
      end
      if (tx_exp.size() == 0) chk(0, "R9", "unexpected tx frame", v, -1);
      else begin
        chk(v == tx_exp[0], "R1", "tx data", v, tx_exp[0]);
        void'(tx_exp.pop_front());
      end
    end
  end

  task automatic set_cfg(input int len, input int par, input int stp);
    b_len = len; b_par = par; b_stop = stp;
    cfg_len_code = 4'(len - 3);
    cfg_parity   = (par == 0) ? 2'b00 : (par == 1) ? 2'b10 : 2'b11;
    cfg_stop     = (stp == 0) ? 2'b00 : (stp == 1) ? 2'b01 : 2'b11;
    @(negedge clk);
  endtask

  task automatic strobe(input bit ten, input bit tdis, input bit ren, input bit rdis);
    cmd_tx_en = ten; cmd_tx_dis = tdis; cmd_rx_en = ren; cmd_rx_dis = rdis;
    @(negedge clk);
    cmd_tx_en = 0; cmd_tx_dis = 0; cmd_rx_en = 0; cmd_rx_dis = 0;
    if (tdis) m_tx_on = 0;
    else if (ten) m_tx_on = 1;
  endtask

  // looped-back character: expect it on the line and back in the receive queue
  task automatic send_tx(input int d);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1; tx_data = 8'(d);
    tx_exp.push_back(d & mask_of(b_len));
    exp_q.push_back(d & mask_of(b_len));
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_drain();
    while (!(stat_tx_idle && tx_exp.size() == 0)) @(negedge clk);
    repeat (300) @(negedge clk);
  endtask

  task automatic drive_bit(input bit v, input int clks);
    drv = v;
    repeat (clks) @(negedge clk);
  endtask

  task automatic send_frame(input int d, input bit bad_par, input bit stop_lvl,
                            input int nstop, input int gap);
    drive_bit(0, BITC);
    for (int i = 0; i < b_len; i++) drive_bit(d[i], BITC);
    if (b_par != 0) drive_bit(par_of(d, b_len, b_par) ^ bad_par, BITC);
    drive_bit(stop_lvl, BITC);
    for (int i = 1; i < nstop; i++) drive_bit(1, BITC);
    if (gap > 0) drive_bit(1, gap);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int lowcnt;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1, "R9", "reset txd", txd, 1);
    chk(tx_ready == 1 && stat_tx_room == 1, "R11", "reset room", tx_ready, 1);
    chk(stat_tx_idle == 1, "R11", "reset idle", stat_tx_idle, 1);
    chk(rx_valid == 0 && stat_rx_avail == 0, "R7", "reset rx empty", rx_valid, 0);

    // R9: pending character held while transmitter is off
    loop = 1'b1;
    set_cfg(8, 0, 1);
    send_tx(8'hA5);
    lowcnt = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (!txd) lowcnt++;
    end
    chk(lowcnt == 0, "R9", "line low while disabled", lowcnt, 0);
    chk(stat_tx_room == 0, "R11", "room with held char", stat_tx_room, 0);
    chk(stat_tx_idle == 0, "R11", "idle with held char", stat_tx_idle, 0);
    strobe(0, 0, 1, 0);
    strobe(1, 0, 0, 0);
    chk(stat_tx_on == 1, "R8", "enable strobe", stat_tx_on, 1);
    wait_drain();
    chk(exp_q.size() == 0, "R9", "held char delivered", exp_q.size(), 0);

    // R13 / R11: back-pressure while shifting
    send_tx(8'h3C);
    send_tx(8'h00);
    chk(tx_ready == 0, "R13", "ready low with slot full", tx_ready, 0);
    send_tx(8'hFF);
    wait_drain();
    chk(exp_q.size() == 0 && tx_exp.size() == 0, "R1", "8N1 loopback drained", exp_q.size(), 0);

    // R2: even parity, 7 bits, data masked
    set_cfg(7, 1, 1);
    send_tx(8'h55); send_tx(8'h7F); send_tx(8'hC3);
    wait_drain();
    chk(exp_q.size() == 0, "R2", "7E1 loopback drained", exp_q.size(), 0);

    // R3: odd parity, 5 bits, two stops
    set_cfg(5, 2, 2);
    send_tx(8'h1F); send_tx(8'h0A);
    wait_drain();
    chk(exp_q.size() == 0, "R3", "5O2 loopback drained", exp_q.size(), 0);

    // R3: half stop, 6 bits
    set_cfg(6, 0, 0);
    send_tx(8'h2A); send_tx(8'h15);
    wait_drain();
    chk(exp_q.size() == 0, "R3", "6N half-stop drained", exp_q.size(), 0);

    // receiver checks with bench-driven line
    loop = 1'b0;
    set_cfg(8, 1, 1);
    exp_q.push_back(16'h4081);
    send_frame(8'h81, 1, 1, 1, BITC);
    repeat (100) @(negedge clk);
    chk(exp_q.size() == 0, "R5", "parity error flag", exp_q.size(), 0);

    set_cfg(8, 0, 1);
    exp_q.push_back(16'h805A);
    send_frame(8'h5A, 0, 0, 1, BITC);
    repeat (100) @(negedge clk);
    chk(exp_q.size() == 0, "R5", "framing error flag", exp_q.size(), 0);

    // R6: break
    exp_q.push_back(16'h8000);
    drive_bit(0, 20*BITC);
    drive_bit(1, 2*BITC);
    chk(exp_q.size() == 0, "R6", "break word", exp_q.size(), 0);

    // R4: only first stop checked
    set_cfg(8, 0, 2);
    exp_q.push_back(16'h0033);
    exp_q.push_back(16'h0044);
    send_frame(8'h33, 0, 1, 1, 0);
    send_frame(8'h44, 0, 1, 2, BITC);
    repeat (100) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "single stop accepted", exp_q.size(), 0);
    exp_q.push_back(16'h8066);
    send_frame(8'h66, 0, 0, 2, BITC);
    repeat (100) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "first stop low flagged", exp_q.size(), 0);

    // R12: short glitch is not a start bit
    drive_bit(0, BITC/4);
    drive_bit(1, 3*BITC);
    chk(rx_valid == 0, "R12", "glitch ignored", rx_valid, 0);

    // R7: overflow
    set_cfg(8, 0, 1);
    rx_ready = 1'b0;
    ovf_cnt = 0;
    send_frame(8'h01, 0, 1, 1, BITC);
    send_frame(8'h02, 0, 1, 1, BITC);
    send_frame(8'h03, 0, 1, 1, BITC);
    repeat (50) @(negedge clk);
    chk(ovf_cnt == 1, "R7", "overflow pulses", ovf_cnt, 1);
    chk(rx_valid == 1 && rx_word == 16'h0001, "R13", "held front word", rx_word, 16'h0001);
    exp_q.push_back(16'h0001);
    exp_q.push_back(16'h0002);
    rx_ready = 1'b1;
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0 && rx_valid == 0, "R7", "two words kept", exp_q.size(), 0);

    // R10: receiver disabled
    strobe(0, 0, 0, 1);
    send_frame(8'h77, 0, 1, 1, BITC);
    repeat (50) @(negedge clk);
    chk(rx_valid == 0, "R10", "no word when disabled", rx_valid, 0);

    // R8: disable wins
    strobe(1, 1, 0, 0);
    chk(stat_tx_on == 0, "R8", "disable wins", stat_tx_on, 0);

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule